// File: doc/BRIEF.md
# Guarded Watchdog Timer

A watchdog peripheral with a three-register software interface. A timeout counter advances on a clock-enable tick and is returned to zero by a kick input. When it reaches the selected limit it raises an interrupt, requests a system reset, or raises an interrupt first and escalates to a reset on the next expiry if that interrupt is left unserviced. Halfway through each period an early-warning flag is raised, with its own enable and a choice between hardware and software clearing.

Software cannot disable the reset path or change the period by accident. Clearing the reset enable or changing the period select needs an unlock bit, which closes by itself a fixed number of cycles after it is written. A sticky watchdog-reset flag keeps the reset enable forced on until software clears the flag. A strap input forces system-reset behaviour whatever the enable bits say.

Top module: `wdt_guarded`

Register map (address on `reg_addr`, all 8 bits wide). CTRL (address 0): bit 7 timeout flag (write 1 clears), bit 6 timeout interrupt enable, bit 5 period select bit 3, bit 4 unlock, bit 3 reset enable, bits 2:0 period select bits 2:0. AUX (address 1): bit 5 early-warning hold mode, bit 3 early-warning flag (write 1 clears), bit 2 early-warning enable, all other bits read 0. STAT (address 2): bit 0 watchdog-reset flag (write 1 clears), other bits read 0. Address 3 reads 0. Read data is registered: `reg_rdata` shows the register addressed one clock edge earlier.

## Requirements
- R1: Writing CTRL with bit 4 set while unlocked is clear opens the unlock window: CTRL bit 4 reads 1, a CTRL write on any of the next UNLOCK_CYCLES (default 4) clock edges is a protected write, and with no such write the bit reads 0 again after that window.
- R2: Outside the window a CTRL write leaves the period select unchanged and can set but not clear the reset enable (bit 3); a protected write loads both from the written data and closes the window.
- R3: While the watchdog-reset flag (STAT bit 0) is 1, CTRL bit 3 reads 1 and a protected write of 0 does not clear it; after software writes 1 to STAT bit 0, the reset enable can be cleared by a protected write.
- R4: The 4-bit period select P (CTRL bit 5 as its top bit, bits 2:0 as its low bits) gives a timeout after 2^(BASE_LOG2+min(P,MAX_CODE)) ticks; codes above MAX_CODE (default 9) behave as MAX_CODE.
- R5: With the strap `fuse_rst` low, enables {reset enable, interrupt enable} select 00 stopped (no timeout ever), 01 interrupt, 10 reset, 11 interrupt then reset; with `fuse_rst` high every timeout requests a reset and raises no interrupt.
- R6: In interrupt-then-reset mode the first timeout sets the timeout flag; a second timeout with the flag still set requests a reset; a pulse on `irq_ack` clears both the flag and the interrupt enable, so the next timeout requests a reset.
- R7: The counter advances only on edges where `tick` is 1; a `kick` returns it to zero, and after a timeout it restarts from zero.
- R8: `rst_req` is high for exactly one cycle per reset request and sets STAT bit 0.
- R9: The early-warning flag (AUX bit 3) is set at the half-period tick and `ew_irq` is flag AND enable; with hold mode 0 an `ew_ack` pulse clears the flag, with hold mode 1 it is cleared only by writing 1 to AUX bit 3.
- R10: Unused register bits read 0, including AUX bits 7:6, whatever is written to them.
- R11: `wd_irq` is the timeout flag AND the interrupt enable; writing 1 to CTRL bit 7 or pulsing `irq_ack` clears the flag, and outside interrupt-then-reset mode the enable is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable for the timeout counter |
| kick | input | 1 | Restarts the counter from zero |
| fuse_rst | input | 1 | Strap forcing system-reset behaviour |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (read and write) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_ack | input | 1 | Timeout interrupt serviced |
| ew_ack | input | 1 | Early-warning interrupt serviced |
| wd_irq | output | 1 | Timeout interrupt request |
| ew_irq | output | 1 | Early-warning interrupt request |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench sweeps all sixteen period codes and times the early warning and the reset in ticks, so a wrong exponent, a missing saturation or a field read from the wrong bit shows up as an off-by-power-of-two count. It probes the unlock window on its last open edge and one edge later, where a counter off by one would either reject a legal write or let the reset enable be cleared late. It drives both escalation paths, serviced and unserviced, where a design that kept the enable after service or reset on the first expiry would show the wrong first-reset tick. It also tries to clear the reset enable while the reset flag is set, gates the tick every other cycle, and checks that hold mode makes an acknowledge ineffective.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_IRQ = 2'd1,
    MODE_RST = 2'd2,
    MODE_ESC = 2'd3
  } wdt_mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_AUX  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int CTRL_TOF   = 7;
  localparam int CTRL_TIE   = 6;
  localparam int CTRL_PS3   = 5;
  localparam int CTRL_UNLK  = 4;
  localparam int CTRL_RSTEN = 3;

  localparam int AUX_HOLD = 5;
  localparam int AUX_EWF  = 3;
  localparam int AUX_EWE  = 2;

  localparam int STAT_WRF = 0;

  function automatic wdt_mode_e mode_of(input logic fuse, input logic rsten,
                                        input logic ien);
    if (fuse) return MODE_RST;
    case ({rsten, ien})
      2'b01:   return MODE_IRQ;
      2'b10:   return MODE_RST;
      2'b11:   return MODE_ESC;
      default: return MODE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_pkg::*;
#(
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we_ctrl,
  input  logic       we_aux,
  input  logic [7:0] wdata,
  input  logic       rflag,
  input  logic       ie_hw_clr,
  output logic       wde_eff,
  output logic       ie,
  output logic [3:0] psel,
  output logic       unlk,
  output logic       ew_hold,
  output logic       ew_en
);

  localparam int WW = $clog2(UNLOCK_CYCLES + 1);

  logic          wde_r;
  logic [WW-1:0] win;

  always_ff @(posedge clk) begin
    if (rst) begin
      wde_r <= 1'b0;
      ie    <= 1'b0;
      psel  <= '0;
      unlk  <= 1'b0;
      win   <= '0;
    end else begin
      if (we_ctrl) begin
        ie <= wdata[CTRL_TIE];
        if (unlk) begin
          wde_r <= wdata[CTRL_RSTEN] | rflag;
          psel  <= {wdata[CTRL_PS3], wdata[2:0]};
          unlk  <= 1'b0;
          win   <= '0;
        end else begin
          wde_r <= wde_r | wdata[CTRL_RSTEN] | rflag;
          if (wdata[CTRL_UNLK]) begin
            unlk <= 1'b1;
            win  <= WW'(UNLOCK_CYCLES - 1);
          end
        end
      end else begin
        wde_r <= wde_r | rflag;
        if (ie_hw_clr) ie <= 1'b0;
        if (unlk) begin
          if (win == '0) unlk <= 1'b0;
          else           win  <= win - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ew_hold <= 1'b0;
      ew_en   <= 1'b0;
    end else if (we_aux) begin
      ew_hold <= wdata[AUX_HOLD];
      ew_en   <= wdata[AUX_EWE];
    end
  end

  assign wde_eff = wde_r | rflag;

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int BASE_LOG2 = 11,
  parameter int MAX_CODE  = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       tick,
  input  logic       kick,
  input  logic [3:0] psel,
  output logic       timeout,
  output logic       half
);

  localparam int CW = BASE_LOG2 + MAX_CODE;
  localparam int SW = $clog2(CW + 1);

  logic [CW-1:0] cnt;
  logic [3:0]    code_sat;
  logic [SW-1:0] shamt;
  logic [CW-1:0] lim_m1;
  logic [CW-1:0] half_m1;
  logic          step;

  always_comb begin
    code_sat = (psel > 4'(MAX_CODE)) ? 4'(MAX_CODE) : psel;
    shamt    = SW'(BASE_LOG2) + SW'(code_sat);
    lim_m1   = ~({CW{1'b1}} << shamt);
    half_m1  = lim_m1 >> 1;
  end

  assign step    = run & tick & ~kick;
  assign timeout = step & (cnt >= lim_m1);
  assign half    = step & (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst || !run || kick) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt >= lim_m1) cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  wdt_mode_e mode,
  input  logic      timeout,
  input  logic      half,
  input  logic      irq_ack,
  input  logic      ew_ack,
  input  logic      ew_hold,
  input  logic      tof_clr,
  input  logic      ewf_clr,
  input  logic      wrf_clr,
  output logic      tof,
  output logic      ewf,
  output logic      wrf,
  output logic      rst_req,
  output logic      ie_hw_clr
);

  logic fire_rst;
  logic fire_irq;

  always_comb begin
    fire_rst = 1'b0;
    fire_irq = 1'b0;
    if (timeout) begin
      case (mode)
        MODE_IRQ: fire_irq = 1'b1;
        MODE_RST: fire_rst = 1'b1;
        MODE_ESC: begin
          if (tof) fire_rst = 1'b1;
          else     fire_irq = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign ie_hw_clr = irq_ack & tof & (mode == MODE_ESC);

  always_ff @(posedge clk) begin
    if (rst) begin
      tof     <= 1'b0;
      ewf     <= 1'b0;
      wrf     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= fire_rst;

      if (fire_irq)                 tof <= 1'b1;
      else if (irq_ack || tof_clr)  tof <= 1'b0;

      if (half)                                ewf <= 1'b1;
      else if (ewf_clr || (ew_ack && !ew_hold)) ewf <= 1'b0;

      if (fire_rst)     wrf <= 1'b1;
      else if (wrf_clr) wrf <= 1'b0;
    end
  end

endmodule

// File: rtl/wdt_guarded.sv
module wdt_guarded
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2     = 11,
  parameter int MAX_CODE      = 9,
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       kick,
  input  logic       fuse_rst,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       irq_ack,
  input  logic       ew_ack,
  output logic       wd_irq,
  output logic       ew_irq,
  output logic       rst_req
);

  logic      we_ctrl, we_aux, we_stat;
  logic      wde_eff, ie, unlk, ew_hold, ew_en;
  logic [3:0] psel;
  logic      tof, ewf, wrf, ie_hw_clr;
  logic      timeout, half;
  wdt_mode_e mode;

  assign we_ctrl = reg_we && (reg_addr == ADDR_CTRL);
  assign we_aux  = reg_we && (reg_addr == ADDR_AUX);
  assign we_stat = reg_we && (reg_addr == ADDR_STAT);

  assign mode = mode_of(fuse_rst, wde_eff, ie);

  wdt_cfg #(.UNLOCK_CYCLES(UNLOCK_CYCLES)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .we_ctrl   (we_ctrl),
    .we_aux    (we_aux),
    .wdata     (reg_wdata),
    .rflag     (wrf),
    .ie_hw_clr (ie_hw_clr),
    .wde_eff   (wde_eff),
    .ie        (ie),
    .psel      (psel),
    .unlk      (unlk),
    .ew_hold   (ew_hold),
    .ew_en     (ew_en)
  );

  wdt_count #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) u_count (
    .clk     (clk),
    .rst     (rst),
    .run     (mode != MODE_OFF),
    .tick    (tick),
    .kick    (kick),
    .psel    (psel),
    .timeout (timeout),
    .half    (half)
  );

  wdt_action u_action (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .timeout   (timeout),
    .half      (half),
    .irq_ack   (irq_ack),
    .ew_ack    (ew_ack),
    .ew_hold   (ew_hold),
    .tof_clr   (we_ctrl && reg_wdata[CTRL_TOF]),
    .ewf_clr   (we_aux && reg_wdata[AUX_EWF]),
    .wrf_clr   (we_stat && reg_wdata[STAT_WRF]),
    .tof       (tof),
    .ewf       (ewf),
    .wrf       (wrf),
    .rst_req   (rst_req),
    .ie_hw_clr (ie_hw_clr)
  );

  assign wd_irq = tof & ie;
  assign ew_irq = ewf & ew_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADDR_CTRL: reg_rdata <= {tof, ie, psel[3], unlk, wde_eff, psel[2:0]};
        ADDR_AUX:  reg_rdata <= {2'b00, ew_hold, 1'b0, ewf, ew_en, 2'b00};
        ADDR_STAT: reg_rdata <= {7'b0, wrf};
        default:   reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/wdt_guarded_chk.sv
module wdt_guarded_chk
  import wdt_pkg::*;
#(
  parameter int UNLOCK_CYCLES = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       unlk,
  input logic [3:0] psel,
  input logic       wrf,
  input logic       tof,
  input logic       fuse_rst,
  input logic       timeout,
  input logic       rst_req,
  input wdt_mode_e  mode
);

  int open_cnt;

  always_ff @(posedge clk) begin
    if (rst || !unlk) open_cnt <= 0;
    else if (open_cnt <= UNLOCK_CYCLES) open_cnt <= open_cnt + 1;
  end

  // R1: the unlock bit never stays open past its window
  a_r1_window_closes: assert property (@(posedge clk) disable iff (rst)
    open_cnt <= UNLOCK_CYCLES);

  // R2: a write outside the window leaves the period select alone
  a_r2_psel_locked: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == ADDR_CTRL && !unlk) |=> $stable(psel));

  // R3: reset flag forces the reset enable as read back
  a_r3_enable_forced: assert property (@(posedge clk) disable iff (rst)
    (wrf && !reg_we && reg_addr == ADDR_CTRL) |=> reg_rdata[CTRL_RSTEN]);

  // R5: strap makes every expiry a reset request
  a_r5_fuse_resets: assert property (@(posedge clk) disable iff (rst)
    (fuse_rst && timeout) |=> rst_req);

  // R5: stopped mode never expires
  a_r5_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF) |-> !timeout);

  // R6: unserviced second expiry escalates
  a_r6_escalate: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ESC && timeout && tof) |=> rst_req);

  // R8: reset request is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R8: reset request leaves the flag set
  a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> wrf);

  // R10: reserved auxiliary bits read zero
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == ADDR_AUX) |-> (reg_rdata[7:6] == 2'b00));

endmodule

bind wdt_guarded wdt_guarded_chk #(.UNLOCK_CYCLES(UNLOCK_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .unlk      (unlk),
  .psel      (psel),
  .wrf       (wrf),
  .tof       (tof),
  .fuse_rst  (fuse_rst),
  .timeout   (timeout),
  .rst_req   (rst_req),
  .mode      (mode)
);

// File: tb/wdt_guarded_test.sv
`timescale 1ns/1ps
module wdt_guarded_test;

  localparam int BASE = 2;
  localparam int MAXC = 9;
  localparam int L0   = 1 << BASE;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, kick = 1'b0, fuse_rst = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq_ack = 1'b0, ew_ack = 1'b0;
  logic       wd_irq, ew_irq, rst_req;

  int checks = 0;
  int fails  = 0;
  int first_rst, first_irq, first_ew, rst_cycles;
  logic [7:0] rv;

  always #4 clk = ~clk;

  wdt_guarded #(.BASE_LOG2(BASE), .MAX_CODE(MAXC), .UNLOCK_CYCLES(4)) uut (
    .clk(clk), .rst(rst), .tick(tick), .kick(kick), .fuse_rst(fuse_rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ack(irq_ack), .ew_ack(ew_ack),
    .wd_irq(wd_irq), .ew_irq(ew_irq), .rst_req(rst_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; reg_wdata = 8'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_kick();
    kick = 1'b1; tick = 1'b1;
    @(posedge clk); @(negedge clk);
    kick = 1'b0; tick = 1'b0;
  endtask

  task automatic pulse_irq_ack();
    irq_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic pulse_ew_ack();
    ew_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    ew_ack = 1'b0;
  endtask

  // runs until n ticks have been sampled; records the tick count at first events
  task automatic run(input int nticks, input bit slow);
    int n = 0;
    int cyc = 0;
    first_rst = -1; first_irq = -1; first_ew = -1; rst_cycles = 0;
    while (n < nticks) begin
      tick = slow ? cyc[0] : 1'b1;
      @(posedge clk);
      if (tick) n++;
      @(negedge clk);
      cyc++;
      if (rst_req) begin
        rst_cycles++;
        if (first_rst < 0) first_rst = n;
      end
      if (wd_irq && first_irq < 0) first_irq = n;
      if (ew_irq && first_ew < 0)  first_ew = n;
    end
    tick = 1'b0;
  endtask

  task automatic restore();
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h80);
    wr(2'd1, 8'h08);
    wr(2'd0, 8'h10);
    wr(2'd0, 8'h00);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(2'd0, rv); check("R1 reset CTRL", rv, 0);
    rd(2'd1, rv); check("R9 reset AUX", rv, 0);
    rd(2'd2, rv); check("R8 reset STAT", rv, 0);
    check("R8 reset rst_req", rst_req, 0);
    check("R11 reset wd_irq", wd_irq, 0);

    // R10 reserved bits
    wr(2'd1, 8'hFF); rd(2'd1, rv); check("R10 AUX unused bits", rv, 8'h24);
    wr(2'd2, 8'hFE); rd(2'd2, rv); check("R10 STAT unused bits", rv, 0);
    rd(2'd3, rv); check("R10 address 3", rv, 0);
    wr(2'd1, 8'h00);

    // R2 locked writes
    wr(2'd0, 8'h27); rd(2'd0, rv); check("R2 psel locked", rv, 0);
    wr(2'd0, 8'h08); rd(2'd0, rv); check("R2 enable settable", rv, 8'h08);
    wr(2'd0, 8'h00); rd(2'd0, rv); check("R2 enable not clearable", rv, 8'h08);
    wr(2'd0, 8'h10); rd(2'd0, rv); check("R1 window open", rv, 8'h18);
    idle(4);         rd(2'd0, rv); check("R1 window closed", rv, 8'h08);

    // R1 last open edge accepts, one later rejects
    wr(2'd0, 8'h18); idle(3); wr(2'd0, 8'h00);
    rd(2'd0, rv); check("R1 fourth edge accepted", rv, 0);
    wr(2'd0, 8'h18); wr(2'd0, 8'h08); idle(3);   // set enable back, window reused
    rd(2'd0, rv); check("R2 protected write loads", rv, 8'h08);
    wr(2'd0, 8'h10); idle(4); wr(2'd0, 8'h00);
    rd(2'd0, rv); check("R1 fifth edge rejected", rv, 8'h08);
    wr(2'd0, 8'h10); wr(2'd0, 8'h00);

    // R4 period sweep with strap forcing reset behaviour
    fuse_rst = 1'b1;
    for (int p = 0; p < 16; p++) begin
      automatic int lim = 1 << (BASE + ((p > MAXC) ? MAXC : p));
      automatic logic [7:0] pd = {2'b00, p[3], 2'b00, p[2:0]};
      wr(2'd2, 8'h01);
      wr(2'd0, 8'h10);
      wr(2'd0, pd);
      rd(2'd0, rv); check($sformatf("R4 field layout code %0d", p), rv, pd);
      wr(2'd1, 8'h0C);
      do_kick();
      run(lim + 1, 1'b0);
      check($sformatf("R4 timeout ticks code %0d", p), first_rst, lim);
      check($sformatf("R9 half-period ticks code %0d", p), first_ew, lim / 2);
      check($sformatf("R8 pulse width code %0d", p), rst_cycles, 1);
      check($sformatf("R5 strap no irq code %0d", p), first_irq, -1);
    end
    rd(2'd2, rv); check("R8 reset flag set", rv, 1);
    fuse_rst = 1'b0;
    restore();

    // R5 stopped
    do_kick(); run(3 * L0, 1'b0);
    check("R5 stopped no reset", first_rst, -1);
    check("R5 stopped no irq", first_irq, -1);

    // R5 / R11 interrupt mode
    wr(2'd0, 8'h40); do_kick(); run(L0, 1'b0);
    check("R5 irq mode irq tick", first_irq, L0);
    check("R5 irq mode no reset", first_rst, -1);
    wr(2'd0, 8'hC0); rd(2'd0, rv);
    check("R11 w1c keeps enable", rv, 8'h40);
    check("R11 irq dropped", wd_irq, 0);
    run(L0, 1'b0); check("R7 restart after timeout", first_irq, L0);
    pulse_irq_ack();
    check("R11 ack clears irq", wd_irq, 0);
    rd(2'd0, rv); check("R11 ack keeps enable", rv, 8'h40);

    // R9 early warning, hardware clear then hold mode
    wr(2'd1, 8'h0C); do_kick(); run(L0 / 2, 1'b0);
    check("R9 warning tick", first_ew, L0 / 2);
    pulse_ew_ack();
    check("R9 ack clears warning", ew_irq, 0);
    wr(2'd1, 8'h24); do_kick(); run(L0 / 2, 1'b0);
    pulse_ew_ack();
    check("R9 hold ignores ack", ew_irq, 1);
    rd(2'd1, rv); check("R9 hold flag kept", rv, 8'h2C);
    wr(2'd1, 8'h2C);
    check("R9 software clear", ew_irq, 0);
    restore();

    // R5 / R8 / R3 reset mode
    wr(2'd0, 8'h08); do_kick(); run(L0 + 2, 1'b0);
    check("R5 reset mode tick", first_rst, L0);
    check("R8 one cycle", rst_cycles, 1);
    check("R5 reset mode no irq", first_irq, -1);
    rd(2'd2, rv); check("R8 flag after reset", rv, 1);
    wr(2'd0, 8'h10); wr(2'd0, 8'h00);
    rd(2'd0, rv); check("R3 enable held by flag", rv, 8'h08);
    wr(2'd2, 8'h01); rd(2'd2, rv); check("R3 flag cleared", rv, 0);
    wr(2'd0, 8'h10); wr(2'd0, 8'h00);
    rd(2'd0, rv); check("R3 enable cleared after flag", rv, 0);

    // R6 unserviced escalation
    wr(2'd0, 8'h48); do_kick(); run(2 * L0 + 1, 1'b0);
    check("R6 first timeout irq", first_irq, L0);
    check("R6 unserviced reset", first_rst, 2 * L0);
    restore();

    // R6 serviced escalation
    wr(2'd0, 8'h48); do_kick(); run(L0, 1'b0);
    check("R6 irq before service", first_irq, L0);
    pulse_irq_ack();
    rd(2'd0, rv); check("R6 service clears flag and enable", rv, 8'h08);
    run(L0 + 1, 1'b0);
    check("R6 serviced then reset", first_rst, L0);
    check("R6 no irq after service", first_irq, -1);
    restore();

    // R5 strap with only interrupt enable
    fuse_rst = 1'b1;
    wr(2'd0, 8'h40); do_kick(); run(L0 + 1, 1'b0);
    check("R5 strap reset tick", first_rst, L0);
    check("R5 strap suppresses irq", first_irq, -1);
    fuse_rst = 1'b0;
    restore();

    // R7 kick and tick gating
    wr(2'd0, 8'h08); do_kick(); run(L0 - 1, 1'b0);
    check("R7 no early timeout", first_rst, -1);
    do_kick(); run(L0, 1'b0);
    check("R7 kick restarts count", first_rst, L0);
    do_kick(); run(L0, 1'b1);
    check("R7 slow tick count", first_rst, L0);
    restore();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule